// File: doc/BRIEF.md
# Conversion Result Window Watcher

This block watches the results of an analog-to-digital converter that serves several input channels and flags the channels whose results fall in, or out of, a programmable window. Software sets an 8-bit upper limit, an 8-bit lower limit, a criterion select (inside or outside the window) and an enable. The converter reports progress through two strobes. The first comes once the upper four result bits are resolved and carries the channel index with that nibble. The second comes when the whole 8-bit result is ready.

In outside mode the block decides early when possible. If the resolved nibble already lies strictly beyond the upper nibble of either limit, the channel is flagged at once and the full compare for that conversion is skipped. Otherwise the decision waits for the full result. Each channel has a sticky flag, which software clears with a masked clear strobe. The interrupt request is the OR of the flags, gated by the enable.

Top module: `conv_window_watch`

## Requirements
- R1: In inside mode (`cfg_outside`=0), a final result `r` with `cfg_lo` <= r <= `cfg_hi` sets the flag of the conversion's channel. A result equal to either limit counts as inside, and a result outside the window sets nothing. The flag is visible one clock edge after the final strobe is sampled.
- R2: In outside mode (`cfg_outside`=1), when no early decision was made, a final result with r < `cfg_lo` or r > `cfg_hi` sets the channel's flag. A result equal to a limit sets nothing.
- R3: In outside mode, a partial strobe whose nibble is greater than `cfg_hi[7:4]` or less than `cfg_lo[7:4]` sets the flag of `chan_in` one edge after that strobe, before the final result arrives.
- R4: A nibble equal to a limit's upper nibble (and not beyond the other limit) makes no early decision. The outcome is left to the full compare.
- R5: A conversion produces at most one event. Once the early check has fired, the final result of that conversion sets no flag, even if the flag was cleared in between.
- R6: In inside mode the partial strobe never sets a flag.
- R7: While `cfg_enable`=0, no conversion sets any flag and `irq` stays low.
- R8: Flags are sticky. `flag_clr` clears the flags whose bits are set in `flag_clr_mask` (bit i is channel i). An event on a channel in the same cycle as its clear leaves that flag set.
- R9: `irq` equals `cfg_enable` AND (any flag set), and follows the flags within the same cycle. Flags are kept while the enable is low.
- R10: The channel index is captured at the partial strobe. The final compare uses that captured index whatever `chan_in` shows later.
- R11: A synchronous active-high `rst` clears all flags, so `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Window checking and interrupt enable |
| cfg_outside | input | 1 | 1: flag results outside the window; 0: flag results inside |
| cfg_hi | input | 8 | Upper window limit |
| cfg_lo | input | 8 | Lower window limit |
| chan_in | input | 2 | Channel of the conversion, valid with `part_valid` |
| part_valid | input | 1 | Upper nibble resolved strobe |
| part_nibble | input | 4 | Upper four result bits |
| final_valid | input | 1 | Full result ready strobe |
| final_result | input | 8 | Full conversion result |
| flag_clr | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 4 | Channels to clear, bit i for channel i |
| flags | output | 4 | Sticky per-channel window flags |
| irq | output | 1 | Interrupt request |

## Verification
Every result lands one rising edge after the strobe that causes it. Early decisions appear after the partial strobe's edge, full-compare decisions after the final strobe's edge, and clears after the clear's edge. `irq` changes with the flags in the same cycle. The bench drives its inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. It compares flags and `irq` to that model at every falling edge, so each result is checked exactly half a cycle after it is due. Directed checks at the same falling edges confirm the boundary cases: the limit equalities, the equal-nibble deferral, and the suppression of the final compare after an early decision.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int RES_W = 8;
  localparam int NIB_W = RES_W / 2;

  typedef logic [RES_W-1:0] res_t;
  typedef logic [NIB_W-1:0] nib_t;

  // inclusive window test
  function automatic logic in_window(res_t v, res_t lo, res_t hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // strict outside test
  function automatic logic out_window(res_t v, res_t lo, res_t hi);
    return (v < lo) || (v > hi);
  endfunction

  // early escape: nibble strictly beyond either limit's upper nibble
  function automatic logic nib_escapes(nib_t n, res_t lo, res_t hi);
    return (n > hi[RES_W-1 -: NIB_W]) || (n < lo[RES_W-1 -: NIB_W]);
  endfunction
endpackage

// File: rtl/cw_early.sv
module cw_early
  import cw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic part_valid,
  input  logic cfg_enable,
  input  logic cfg_outside,
  input  nib_t part_nibble,
  input  res_t cfg_lo,
  input  res_t cfg_hi,
  output logic early_fire
);
  logic escapes;

  always_comb begin
    escapes    = nib_escapes(part_nibble, cfg_lo, cfg_hi);
    early_fire = part_valid && cfg_enable && cfg_outside && escapes;
  end

  // early decisions exist only in outside mode
  assert_early_outside_only_R6: assert property (@(posedge clk) disable iff (rst)
    early_fire |-> cfg_outside);

  // a nibble tied to both limits' nibbles never decides early
  assert_equal_nibble_defers_R4: assert property (@(posedge clk) disable iff (rst)
    (part_nibble == cfg_hi[RES_W-1 -: NIB_W] && part_nibble == cfg_lo[RES_W-1 -: NIB_W])
      |-> !early_fire);
endmodule

// File: rtl/cw_track.sv
module cw_track #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            part_valid,
  input  logic [CH_W-1:0] chan_in,
  input  logic            early_fire,
  output logic [CH_W-1:0] conv_ch,
  output logic            early_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_ch    <= '0;
      early_done <= 1'b0;
    end else if (part_valid) begin
      conv_ch    <= chan_in;
      early_done <= early_fire;
    end
  end

  // channel held between partial strobes
  assert_channel_held_R10: assert property (@(posedge clk) disable iff (rst)
    !part_valid |=> $stable(conv_ch));
endmodule

// File: rtl/cw_final.sv
module cw_final
  import cw_pkg::*;
(
  input  logic final_valid,
  input  logic cfg_enable,
  input  logic cfg_outside,
  input  logic early_done,
  input  res_t final_result,
  input  res_t cfg_lo,
  input  res_t cfg_hi,
  output logic final_fire
);
  logic hit;

  always_comb begin
    hit = cfg_outside ? out_window(final_result, cfg_lo, cfg_hi)
                      : in_window(final_result, cfg_lo, cfg_hi);
    final_fire = final_valid && cfg_enable && !early_done && hit;
  end
endmodule

// File: rtl/cw_status.sv
module cw_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_vec,
  input  logic              flag_clr,
  input  logic [NUM_CH-1:0] flag_clr_mask,
  output logic [NUM_CH-1:0] flags_q
);
  logic [NUM_CH-1:0] clr_bits;

  always_comb clr_bits = flag_clr ? flag_clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_bits) | ev_vec;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr_bits[i]) |=> flags_q[i]);
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
      ev_vec[i] |=> flags_q[i]);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_bits[i] && !ev_vec[i]) |=> !flags_q[i]);
  end
endmodule

// File: rtl/conv_window_watch.sv
module conv_window_watch
  import cw_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_outside,
  input  logic [RES_W-1:0]  cfg_hi,
  input  logic [RES_W-1:0]  cfg_lo,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              part_valid,
  input  logic [NIB_W-1:0]  part_nibble,
  input  logic              final_valid,
  input  logic [RES_W-1:0]  final_result,
  input  logic              flag_clr,
  input  logic [NUM_CH-1:0] flag_clr_mask,
  output logic [NUM_CH-1:0] flags,
  output logic              irq
);
  logic              early_fire;
  logic              final_fire;
  logic              early_done;
  logic [CH_W-1:0]   conv_ch;
  logic [NUM_CH-1:0] ev_vec;
  logic [NUM_CH-1:0] flags_q;

  cw_early u_early (
    .clk(clk), .rst(rst), .part_valid(part_valid), .cfg_enable(cfg_enable),
    .cfg_outside(cfg_outside), .part_nibble(part_nibble), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .early_fire(early_fire)
  );

  cw_track #(.CH_W(CH_W)) u_track (
    .clk(clk), .rst(rst), .part_valid(part_valid), .chan_in(chan_in),
    .early_fire(early_fire), .conv_ch(conv_ch), .early_done(early_done)
  );

  cw_final u_final (
    .final_valid(final_valid), .cfg_enable(cfg_enable), .cfg_outside(cfg_outside),
    .early_done(early_done), .final_result(final_result), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .final_fire(final_fire)
  );

  // route each decision to the proper channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ev
    assign ev_vec[i] = (early_fire && chan_in == CH_W'(i)) ||
                       (final_fire && conv_ch == CH_W'(i));
  end

  cw_status #(.NUM_CH(NUM_CH)) u_status (
    .clk(clk), .rst(rst), .ev_vec(ev_vec), .flag_clr(flag_clr),
    .flag_clr_mask(flag_clr_mask), .flags_q(flags_q)
  );

  assign flags = flags_q;
  assign irq   = cfg_enable && (|flags_q);

  // one decision per cycle and per conversion
  assert_single_event_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev_vec));
  assert_no_final_after_early_R5: assert property (@(posedge clk) disable iff (rst)
    (early_fire && !final_valid) |=> (final_valid && !part_valid) |-> !final_fire);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> (ev_vec == '0));
  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (flags == '0 && !irq));
endmodule

// File: tb/test_conv_window_watch.sv
`timescale 1ns/1ps
module test_conv_window_watch;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_enable, cfg_outside;
  logic [7:0] cfg_hi, cfg_lo;
  logic [1:0] chan_in;
  logic       part_valid;
  logic [3:0] part_nibble;
  logic       final_valid;
  logic [7:0] final_result;
  logic       flag_clr;
  logic [3:0] flag_clr_mask;
  logic [3:0] flags;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  conv_window_watch i_conv_window_watch (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_outside(cfg_outside),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .chan_in(chan_in), .part_valid(part_valid),
    .part_nibble(part_nibble), .final_valid(final_valid), .final_result(final_result),
    .flag_clr(flag_clr), .flag_clr_mask(flag_clr_mask), .flags(flags), .irq(irq)
  );

  // behavioural reference model
  int m_flags = 0;
  int m_ch = 0;
  bit m_decided = 0;

  always @(posedge clk) begin
    int ev;
    int v;
    bit hit;
    ev = 0;
    if (rst) begin
      m_flags = 0; m_ch = 0; m_decided = 0;
    end else begin
      if (part_valid) begin
        m_ch = chan_in;
        m_decided = 0;
        if (cfg_enable && cfg_outside &&
            (part_nibble > cfg_hi / 16 || part_nibble < cfg_lo / 16)) begin
          ev = 1 << chan_in;
          m_decided = 1;
        end
      end
      if (final_valid && cfg_enable && !m_decided) begin
        v = final_result;
        if (cfg_outside) hit = (v < cfg_lo) || (v > cfg_hi);
        else             hit = (v >= cfg_lo) && (v <= cfg_hi);
        if (hit) ev = ev | (1 << m_ch);
      end
      if (flag_clr) m_flags = m_flags & ~int'(flag_clr_mask);
      m_flags = m_flags | ev;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (flags !== m_flags[3:0] || irq !== (cfg_enable && m_flags != 0)) begin
        failures++;
        $display("FAIL R8/R9 model compare: flags=%b irq=%b expected flags=%b irq=%b",
                 flags, irq, m_flags[3:0], (cfg_enable && m_flags != 0));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<=20000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [3:0] exp);
    logic exp_irq;
    exp_irq = cfg_enable && (exp != 4'b0);
    checks++;
    if (flags !== exp || irq !== exp_irq) begin
      failures++;
      $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b", req, flags, irq, exp, exp_irq);
    end
  endtask

  task automatic do_part(logic [1:0] ch, logic [3:0] nib);
    part_valid = 1; chan_in = ch; part_nibble = nib;
    @(negedge clk);
    part_valid = 0;
  endtask

  task automatic do_final(logic [7:0] res);
    final_valid = 1; final_result = res;
    @(negedge clk);
    final_valid = 0;
  endtask

  task automatic do_clr(logic [3:0] mask);
    flag_clr = 1; flag_clr_mask = mask;
    @(negedge clk);
    flag_clr = 0;
  endtask

  initial begin
    rst = 1; cfg_enable = 1; cfg_outside = 0; cfg_hi = 8'hB0; cfg_lo = 8'h40;
    chan_in = 0; part_valid = 0; part_nibble = 0; final_valid = 0;
    final_result = 0; flag_clr = 0; flag_clr_mask = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset", 4'b0000);
    rst = 0;
    @(negedge clk);

    // R1 inside mode, middle and both equalities
    do_part(2'd1, 4'h6); chk("R6 no early in inside mode", 4'b0000);
    do_final(8'h60);     chk("R1 inside mid", 4'b0010);
    do_part(2'd2, 4'h4); do_final(8'h40); chk("R1 equal low", 4'b0110);
    do_part(2'd3, 4'hB); do_final(8'hB0); chk("R1 equal high", 4'b1110);
    do_clr(4'b1111);     chk("R8 clear all", 4'b0000);
    do_part(2'd0, 4'hB); do_final(8'hB1); chk("R1 just above is not inside", 4'b0000);
    do_part(2'd0, 4'h3); do_final(8'h3F); chk("R1 just below is not inside", 4'b0000);

    // R6: escaping nibble ignored in inside mode
    do_part(2'd0, 4'hF); chk("R6 partial ignored", 4'b0000);
    do_final(8'h50);     chk("R6 final decides", 4'b0001);
    do_clr(4'b0001);

    // R3 early decision, R5 suppression
    cfg_outside = 1;
    do_part(2'd0, 4'hC); chk("R3 early high", 4'b0001);
    do_clr(4'b0001);     chk("R8 clear one", 4'b0000);
    do_final(8'hC5);     chk("R5 final suppressed", 4'b0000);
    do_part(2'd2, 4'h3); chk("R3 early low", 4'b0100);
    do_final(8'h30);     chk("R5 still one event", 4'b0100);
    do_clr(4'b0100);

    // R4 equal nibble defers, R2 full compare
    do_part(2'd1, 4'hB); chk("R4 high nibble defers", 4'b0000);
    do_final(8'hB5);     chk("R2 above high", 4'b0010);
    do_part(2'd3, 4'h4); chk("R4 low nibble defers", 4'b0010);
    do_final(8'h40);     chk("R2 equal low not outside", 4'b0010);
    do_part(2'd3, 4'h4); do_final(8'h3F); chk("R2 below low", 4'b1010);
    do_part(2'd0, 4'hB); do_final(8'hB0); chk("R2 equal high not outside", 4'b1010);

    // R9 irq gating, flags retained; R7 disabled
    cfg_enable = 0; @(negedge clk); chk("R9 irq gated off", 4'b1010);
    do_part(2'd0, 4'hF); do_final(8'hFF); chk("R7 disabled no flag", 4'b1010);
    do_part(2'd2, 4'h0); do_final(8'h00); chk("R7 disabled no flag ch2", 4'b1010);
    cfg_enable = 1; @(negedge clk); chk("R9 irq back", 4'b1010);
    do_clr(4'b1010); chk("R8 clear mask", 4'b0000);

    // R10 channel captured at partial
    do_part(2'd2, 4'h8); chan_in = 2'd0; @(negedge clk);
    do_final(8'hF0);     chk("R10 captured channel", 4'b0100);

    // R8 event wins over same-cycle clear; mask clears only its bits
    do_part(2'd1, 4'hB); do_final(8'hC0); chk("R8 setup", 4'b0110);
    do_part(2'd1, 4'hB);
    final_valid = 1; final_result = 8'hD0; flag_clr = 1; flag_clr_mask = 4'b0010;
    @(negedge clk);
    final_valid = 0; flag_clr = 0;
    chk("R8 event beats clear", 4'b0110);
    do_clr(4'b0100); chk("R8 selective clear", 4'b0010);

    // R11 reset mid-run
    rst = 1; @(negedge clk); chk("R11 reset clears", 4'b0000);
    rst = 0; @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule